// File: doc/BRIEF.md
# Forward 4x4 Block Transform Engine (Core Integer / Hadamard)

This engine takes one 4x4 block of signed 16-bit values and returns its two-dimensional forward transform. A per-block mode bit selects one of two kernels. The core integer kernel is used on prediction residual blocks. The 4x4 Hadamard kernel is used on the block that gathers the sixteen DC terms. Both kernels share one multiplier-free butterfly datapath. A first registered pass transforms each row, and a second registered pass transforms each column. Each pass has four 1-D butterfly lanes working side by side.

The whole block arrives in parallel with a start pulse and leaves in parallel with a done pulse exactly two clock edges later. Because each pass is a pipeline register, a new block can be started on every cycle and modes can alternate freely between blocks. For core blocks the engine also drives the (0,0) term on a separate DC port, which a later stage collects for the Hadamard path.

Top module: `xf_core`

## Requirements
- R1: While and after synchronous reset (rst high, active-high), and until the first result, done and dc_valid are 0 and blk_out and dc_out are all zero.
- R2: A block presented with start high at a rising edge produces done high for exactly one cycle after the second following rising edge, with its result on blk_out in that same cycle.
- R3: Coefficient (r,c), with r the row and c the column, sits at bit slice [16*(4*r+c) +: 16] of blk_in and blk_out. With mode = 0 (core integer), blk_out = T·X·Tᵀ, where T has rows (1,1,1,1), (2,1,-1,-2), (1,-1,-1,1) and (1,-2,2,-1).
- R4: With mode = 1 (Hadamard), blk_out = (H·X·H)/2, where H has rows (1,1,1,1), (1,1,-1,-1), (1,-1,-1,1) and (1,-1,1,-1). The halving is an arithmetic right shift that rounds toward zero.
- R5: For a mode = 0 block, dc_valid is high in its done cycle, and dc_out equals the (0,0) output coefficient.
- R6: For a mode = 1 block, dc_valid stays low and dc_out is zero in its done cycle.
- R7: Starts on consecutive cycles are all accepted, and each result appears in start order with the mode it was started with.
- R8: Sums are carried at full precision internally, and each output coefficient is the low 16 bits (two's complement) of the exact result.
- R9: In any cycle where done is low, blk_out holds its previous value.
- R10: While start is low, blk_in and mode have no effect: no done is raised and blk_out does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Accept blk_in and mode at this edge |
| mode | input | 1 | 0 = core integer kernel, 1 = Hadamard kernel |
| blk_in | input | 256 | 16 signed 16-bit input coefficients |
| done | output | 1 | Result valid on blk_out this cycle |
| blk_out | output | 256 | 16 signed 16-bit transformed coefficients |
| dc_out | output | 16 | (0,0) term of a core-mode result, else zero |
| dc_valid | output | 1 | dc_out carries a core-mode DC term |

## Verification
The busiest overlap is one block finishing in the output stage while a later block, possibly of the other mode, is being accepted by the row stage in the same cycle. The bench provokes this by raising start on four consecutive cycles with alternating modes. It then checks every done-cycle result and DC port against a matrix product computed in the bench, so that any mixing of data or mode between the two stages appears as a mismatch. A follow-up idle stretch, with blk_in changing and start low, confirms that nothing leaks in once the pipeline has drained.

// File: rtl/xf_pkg.sv
package xf_pkg;

    // Coefficient geometry of one block
    localparam int XF_DIM    = 4;
    localparam int XF_N      = XF_DIM * XF_DIM;
    localparam int XF_COEF_W = 16;

    // Bit growth of one 1-D pass: worst-case row gain is 6, so 3 bits
    localparam int XF_GROW   = 3;

    typedef enum logic {
        XF_CORE = 1'b0,
        XF_HAD  = 1'b1
    } xf_mode_e;

    // Flat index of lane element k in lane g: rows for the first pass,
    // columns for the second pass.
    function automatic int xf_lane_idx(input bit column, input int g, input int k);
        return column ? (k * XF_DIM + g) : (g * XF_DIM + k);
    endfunction

endpackage

// File: rtl/xf_bfly.sv
module xf_bfly
    import xf_pkg::*;
#(
    parameter int W = 16,
    localparam int OW = W + XF_GROW
) (
    input  xf_mode_e                   mode,
    input  logic [XF_DIM-1:0][W-1:0]   x,
    output logic [XF_DIM-1:0][OW-1:0]  y
);

    logic signed [OW-1:0] e0, e1, e2, e3;
    logic signed [OW-1:0] s0, s1, d0, d1;
    logic signed [OW-1:0] odd1, odd3;

    // Sign extension to the grown width
    assign e0 = {{XF_GROW{x[0][W-1]}}, x[0]};
    assign e1 = {{XF_GROW{x[1][W-1]}}, x[1]};
    assign e2 = {{XF_GROW{x[2][W-1]}}, x[2]};
    assign e3 = {{XF_GROW{x[3][W-1]}}, x[3]};

    // Shared first butterfly level
    assign s0 = e0 + e3;
    assign s1 = e1 + e2;
    assign d0 = e0 - e3;
    assign d1 = e1 - e2;

    // Odd outputs differ between kernels: weights of 2 only in core mode
    always_comb begin
        if (mode == XF_CORE) begin
            odd1 = (d0 <<< 1) + d1;
            odd3 = d0 - (d1 <<< 1);
        end else begin
            odd1 = d0 + d1;
            odd3 = d0 - d1;
        end
    end

    assign y[0] = s0 + s1;
    assign y[1] = odd1;
    assign y[2] = s0 - s1;
    assign y[3] = odd3;

endmodule

// File: rtl/xf_pass.sv
module xf_pass
    import xf_pkg::*;
#(
    parameter int IN_W   = 16,
    parameter bit COLUMN = 1'b0,
    localparam int OUT_W = IN_W + XF_GROW
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         vld_i,
    input  xf_mode_e                     mode_i,
    input  logic [XF_N-1:0][IN_W-1:0]    dat_i,
    output logic                         vld_o,
    output xf_mode_e                     mode_o,
    output logic [XF_N-1:0][OUT_W-1:0]   dat_o
);

    logic [XF_N-1:0][OUT_W-1:0] nxt;

    for (genvar g = 0; g < XF_DIM; g++) begin : g_lane
        logic [XF_DIM-1:0][IN_W-1:0]  lane_in;
        logic [XF_DIM-1:0][OUT_W-1:0] lane_out;

        for (genvar k = 0; k < XF_DIM; k++) begin : g_elem
            localparam int IDX = xf_lane_idx(COLUMN, g, k);
            assign lane_in[k] = dat_i[IDX];
            assign nxt[IDX]   = lane_out[k];
        end

        xf_bfly #(.W(IN_W)) u_bfly (
            .mode (mode_i),
            .x    (lane_in),
            .y    (lane_out)
        );
    end

    // Pipeline register: data and mode load only with a valid block
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            mode_o <= XF_CORE;
            dat_o  <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                mode_o <= mode_i;
                dat_o  <= nxt;
            end
        end
    end

endmodule

// File: rtl/xf_core.sv
module xf_core
    import xf_pkg::*;
#(
    parameter int COEF_W = XF_COEF_W,
    localparam int MID_W  = COEF_W + XF_GROW,
    localparam int WIDE_W = COEF_W + 2 * XF_GROW,
    localparam int BLK_W  = XF_N * COEF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mode,
    input  logic [BLK_W-1:0]  blk_in,
    output logic              done,
    output logic [BLK_W-1:0]  blk_out,
    output logic [COEF_W-1:0] dc_out,
    output logic              dc_valid
);

    logic [XF_N-1:0][COEF_W-1:0] in_arr;
    logic                        vld1, vld2;
    xf_mode_e                    mode1, mode2;
    logic [XF_N-1:0][MID_W-1:0]  row_dat;
    logic [XF_N-1:0][WIDE_W-1:0] col_dat;
    logic [XF_N-1:0][COEF_W-1:0] out_arr;

    assign in_arr = blk_in;

    // Pass 1: rows
    xf_pass #(.IN_W(COEF_W), .COLUMN(1'b0)) u_row (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (start),
        .mode_i (xf_mode_e'(mode)),
        .dat_i  (in_arr),
        .vld_o  (vld1),
        .mode_o (mode1),
        .dat_o  (row_dat)
    );

    // Pass 2: columns
    xf_pass #(.IN_W(MID_W), .COLUMN(1'b1)) u_col (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (vld1),
        .mode_i (mode1),
        .dat_i  (row_dat),
        .vld_o  (vld2),
        .mode_o (mode2),
        .dat_o  (col_dat)
    );

    // Final scaling: Hadamard results halved toward zero, then truncated
    for (genvar i = 0; i < XF_N; i++) begin : g_out
        logic signed [WIDE_W-1:0] wv, bias, half;
        always_comb begin
            wv   = col_dat[i];
            bias = {{(WIDE_W-1){1'b0}}, wv[WIDE_W-1]};
            half = (wv + bias) >>> 1;
            out_arr[i] = (mode2 == XF_HAD) ? half[COEF_W-1:0] : wv[COEF_W-1:0];
        end
    end

    assign blk_out  = out_arr;
    assign done     = vld2;
    assign dc_valid = vld2 && (mode2 == XF_CORE);
    assign dc_out   = (mode2 == XF_CORE) ? out_arr[0] : '0;

endmodule

// File: rtl/xf_core_chk.sv
module xf_core_chk #(
    parameter int BLK_W  = 256,
    parameter int COEF_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              mode,
    input logic              done,
    input logic [BLK_W-1:0]  blk_out,
    input logic [COEF_W-1:0] dc_out,
    input logic              dc_valid
);

    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst) age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start |-> ##2 done);  // R2

    AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2 && done) |-> $past(start, 2));  // R2

    AST_DC_MATCHES_OUT: assert property (@(posedge clk) disable iff (rst)
        dc_valid |-> (done && dc_out == blk_out[COEF_W-1:0]));  // R5

    AST_DC_CORE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2 && dc_valid) |-> ($past(mode, 2) == 1'b0));  // R5

    AST_HAD_NO_DC: assert property (@(posedge clk) disable iff (rst)
        (done && !dc_valid) |-> (dc_out == '0));  // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1 && !done) |-> $stable(blk_out));  // R9

endmodule

bind xf_core xf_core_chk #(.BLK_W(BLK_W), .COEF_W(COEF_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .mode     (mode),
    .done     (done),
    .blk_out  (blk_out),
    .dc_out   (dc_out),
    .dc_valid (dc_valid)
);

// File: tb/tb_xf_core.sv
module tb_xf_core;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         mode = 1'b0;
    logic [255:0] blk_in = '0;
    logic         done;
    logic [255:0] blk_out;
    logic [15:0]  dc_out;
    logic         dc_valid;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    xf_core dut (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .mode     (mode),
        .blk_in   (blk_in),
        .done     (done),
        .blk_out  (blk_out),
        .dc_out   (dc_out),
        .dc_valid (dc_valid)
    );

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Kernel weights from the requirements
    function automatic int kw(input bit had, input int r, input int c);
        int core_t [4][4] = '{'{1, 1, 1, 1}, '{2, 1, -1, -2}, '{1, -1, -1, 1}, '{1, -2, 2, -1}};
        int had_t  [4][4] = '{'{1, 1, 1, 1}, '{1, 1, -1, -1}, '{1, -1, -1, 1}, '{1, -1, 1, -1}};
        return had ? had_t[r][c] : core_t[r][c];
    endfunction

    function automatic logic [255:0] ref_xf(input logic [255:0] b, input bit had);
        logic [255:0] res = '0;
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 4; k++) begin
                int acc = 0;
                for (int i = 0; i < 4; i++) begin
                    for (int j = 0; j < 4; j++) begin
                        logic signed [15:0] xv = b[16*(4*i+j) +: 16];
                        acc += kw(had, m, i) * int'(xv) * kw(had, k, j);
                    end
                end
                if (had) acc = acc / 2;
                res[16*(4*m+k) +: 16] = acc[15:0];
            end
        end
        return res;
    endfunction

    function automatic logic [255:0] make_blk(input int kind, input int seed);
        logic [255:0] b;
        for (int i = 0; i < 16; i++) begin
            int v;
            case (kind)
                0: v = i + 1;
                1: v = (i % 2) ? -(i * 37 + seed) : (i * 53 + seed);
                2: v = i * 7 - 50 + seed;
                3: v = 32767;
                4: v = -32768;
                default: v = (seed * 131 + i * 977) % 4000 - 2000;
            endcase
            b[16*i +: 16] = v[15:0];
        end
        return b;
    endfunction

    // One isolated block: latency, result, DC port and pulse width
    task automatic run_one(input logic [255:0] b, input bit had, input string rq);
        logic [255:0] exp = ref_xf(b, had);
        @(negedge clk);
        blk_in = b; mode = had; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 done early", {255'd0, done}, 256'd0);
        @(negedge clk);
        check("R2 done", {255'd0, done}, 256'd1);
        check(rq, blk_out, exp);
        if (!had) begin
            check("R5 dc_valid", {255'd0, dc_valid}, 256'd1);
            check("R5 dc_out", {240'd0, dc_out}, {240'd0, exp[15:0]});
        end else begin
            check("R6 dc_valid", {255'd0, dc_valid}, 256'd0);
            check("R6 dc_out", {240'd0, dc_out}, 256'd0);
        end
        @(negedge clk);
        check("R2 single pulse", {255'd0, done}, 256'd0);
    endtask

    task automatic t_reset();
        check("R1 done", {255'd0, done}, 256'd0);
        check("R1 dc_valid", {255'd0, dc_valid}, 256'd0);
        check("R1 blk_out", blk_out, 256'd0);
        check("R1 dc_out", {240'd0, dc_out}, 256'd0);
    endtask

    task automatic t_core();
        run_one(make_blk(0, 0), 1'b0, "R3 core ramp");
        run_one(make_blk(1, 3), 1'b0, "R3 core signed");
    endtask

    task automatic t_had();
        run_one(make_blk(2, 1), 1'b1, "R4 hadamard rounding");
        run_one(make_blk(1, 0), 1'b1, "R4 hadamard signed");
    endtask

    task automatic t_wrap();
        run_one(make_blk(3, 0), 1'b0, "R8 core wrap");
        run_one(make_blk(4, 0), 1'b1, "R8 hadamard wrap");
    endtask

    // Back-to-back starts with alternating modes
    task automatic t_stream();
        logic [255:0] blks [4];
        for (int n = 0; n < 4; n++) blks[n] = make_blk(5, n + 7);
        for (int n = 0; n < 6; n++) begin
            @(negedge clk);
            if (n >= 2) begin
                bit hb = ((n - 2) % 2) == 1;
                logic [255:0] exp = ref_xf(blks[n-2], hb);
                check("R7 stream done", {255'd0, done}, 256'd1);
                check("R7 stream data", blk_out, exp);
                check("R7 stream dc_valid", {255'd0, dc_valid}, {255'd0, !hb});
            end
            if (n < 4) begin
                blk_in = blks[n]; mode = (n % 2) == 1; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        @(negedge clk);
        check("R7 stream drained", {255'd0, done}, 256'd0);
    endtask

    // Start low: inputs change but nothing moves
    task automatic t_idle();
        logic [255:0] held;
        @(negedge clk);
        held = blk_out;
        for (int n = 0; n < 4; n++) begin
            blk_in = make_blk(5, 40 + n); mode = n[0]; start = 1'b0;
            @(negedge clk);
            check("R10 no done while idle", {255'd0, done}, 256'd0);
            check("R9 blk_out held", blk_out, held);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_core();
        t_had();
        t_wrap();
        t_stream();
        t_idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule